// File: doc/BRIEF.md
# Audio Frame Sequencer Timer

This block divides an audio frame into a fixed series of timed steps and announces each step boundary as it passes. A 16-bit down-counter advances only on cycles where `tick_i` is high. When the counter runs out, the block emits a one-cycle event carrying the index of the step that just ended. It then moves to the next step and reloads the counter from an interval table. The table depends on the sequencing mode (four-step or five-step) and on the region input.

Software chooses the mode with a byte written through a strobe. The write does not act at once. It is held and applied a few ticks later, and the delay depends on the parity of the cycle the write arrived on. When the held byte is applied, the sequence restarts at step 0, and `wr_apply_o` pulses for one cycle. Hard and soft reset requests restart the sequence and queue a synthetic pending write, which behaves the same way as a real one.

Top module: `audio_frame_seq`

## Requirements
- R1: After `rst_ni` is released, the block is in four-step mode at step 0 with 7457 ticks loaded and nothing pending. No event or apply pulse occurs until the counter runs out, and the first boundary then reports step 0.
- R2: Bit 7 of an applied byte selects the mode: 1 gives five-step mode and 0 gives four-step mode. The other bits are ignored.
- R3: In region codes 0, 2 and 3, the per-step tick counts for steps 0 to 5 are 7457, 7456, 7458, 7457, 1, 1 in four-step mode, and 7457, 7456, 7458, 7458, 7452, 1 in five-step mode.
- R4: In region code 1, the per-step tick counts are 8313, 8314, 8312, 8313, 1, 1 in four-step mode, and 8313, 8314, 8312, 8314, 8312, 1 in five-step mode.
- R5: On each tick the counter drops by one. When it reaches zero, `evt_valid_o` is high for the following cycle with `evt_step_o` set to the step that just ended. The step then advances, wrapping from 5 to 0, and the counter reloads with the new step's count.
- R6: A write is applied on the 3rd tick after the write cycle if `wr_odd_i` was low, or on the 4th tick if it was high. `wr_apply_o` is high for exactly the one cycle after the applying edge, and no event is reported in that cycle.
- R7: Applying a byte sets the mode and returns to step 0 with step 0's count loaded. In five-step mode, one tick of the count is consumed at once, so the first boundary comes one tick earlier than in four-step mode.
- R8: A write that arrives while another is pending replaces the held byte and restarts the delay. This includes a write on the very cycle the earlier one would have applied.
- R9: A hard reset request forces four-step mode and returns to step 0 with a fresh count. It also queues a pending byte with bit 7 clear, due 3 ticks later.
- R10: A soft reset request keeps the current mode and returns to step 0 with a fresh count. It queues a pending byte whose bit 7 equals the current mode bit, due 3 ticks later.
- R11: A change of `region_i` leaves the interval in progress untouched and takes effect at the next counter reload.
- R12: While `tick_i` is low, neither the counter nor the write delay moves, and no event or apply pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Cycle enable for counter and write delay |
| wr_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Written byte; bit 7 selects the mode |
| wr_odd_i | input | 1 | Parity of the write cycle (1 = odd) |
| region_i | input | 2 | Region code; 1 selects the longer tables |
| hard_rst_i | input | 1 | Hard reset request |
| soft_rst_i | input | 1 | Soft reset request |
| evt_valid_o | output | 1 | Step boundary event |
| evt_step_o | output | 3 | Index of the step that just ended |
| wr_apply_o | output | 1 | Held write has just taken effect |

## Verification
The bench runs whole four-step and five-step frames in both table families. An off-by-one in an interval, or a wrong step wrap, shows up there as an event that lands on the wrong cycle or carries the wrong index. Writes are issued with both parities, under a gapped tick enable, and back to back, including one that lands on the cycle the previous write would have applied. A design that counts delay on clocks rather than ticks, or that lets a stale write apply, produces `wr_apply_o` at the wrong time. Soft and hard resets are issued in five-step mode, where keeping or dropping the mode changes the first boundary by one tick. A region switch in the middle of an interval catches a design that reloads the running count at once.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int CNT_W  = 16;
  localparam int STEP_N = 6;
  localparam int STEP_W = $clog2(STEP_N);

  typedef enum logic {
    MODE_FOUR = 1'b0,
    MODE_FIVE = 1'b1
  } seq_mode_e;

  function automatic logic [CNT_W-1:0] step_interval(
    input logic              long_tab,
    input seq_mode_e         mode,
    input logic [STEP_W-1:0] idx
  );
    logic [CNT_W-1:0] v;
    v = 16'd1;
    if (long_tab) begin
      case (idx)
        3'd0: v = 16'd8313;
        3'd1: v = 16'd8314;
        3'd2: v = 16'd8312;
        3'd3: v = (mode == MODE_FIVE) ? 16'd8314 : 16'd8313;
        3'd4: v = (mode == MODE_FIVE) ? 16'd8312 : 16'd1;
        default: v = 16'd1;
      endcase
    end else begin
      case (idx)
        3'd0: v = 16'd7457;
        3'd1: v = 16'd7456;
        3'd2: v = 16'd7458;
        3'd3: v = (mode == MODE_FIVE) ? 16'd7458 : 16'd7457;
        3'd4: v = (mode == MODE_FIVE) ? 16'd7452 : 16'd1;
        default: v = 16'd1;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/afs_interval_lut.sv
module afs_interval_lut #(
  parameter int CNT_W  = afs_pkg::CNT_W,
  parameter int STEP_W = afs_pkg::STEP_W
) (
  input  logic               long_tab_i,
  input  afs_pkg::seq_mode_e mode_i,
  input  logic [STEP_W-1:0]  idx_i,
  output logic [CNT_W-1:0]   ticks_o
);
  always_comb begin
    ticks_o = CNT_W'(afs_pkg::step_interval(long_tab_i, mode_i, 3'(idx_i)));
  end
endmodule

// File: rtl/afs_write_queue.sv
module afs_write_queue #(
  parameter int DLY_W    = 3,
  parameter int DLY_EVEN = 3,
  parameter int DLY_ODD  = 4,
  parameter int DLY_RST  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_i,
  input  logic wr_five_i,
  input  logic wr_odd_i,
  input  logic rst_any_i,
  input  logic rst_five_i,
  output logic apply_o,
  output logic apply_five_o,
  output logic apply_pulse_o
);
  logic             pend_q;
  logic             five_q;
  logic [DLY_W-1:0] dly_q;

  // Fresh writes and resets supersede a write that is due this cycle
  assign apply_o      = pend_q && tick_i && (dly_q == DLY_W'(1)) && !wr_i && !rst_any_i;
  assign apply_five_o = five_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      five_q        <= 1'b0;
      dly_q         <= '0;
      apply_pulse_o <= 1'b0;
    end else begin
      apply_pulse_o <= apply_o;
      if (rst_any_i) begin
        pend_q <= 1'b1;
        five_q <= rst_five_i;
        dly_q  <= DLY_W'(DLY_RST);
      end else if (wr_i) begin
        pend_q <= 1'b1;
        five_q <= wr_five_i;
        dly_q  <= wr_odd_i ? DLY_W'(DLY_ODD) : DLY_W'(DLY_EVEN);
      end else if (apply_o) begin
        pend_q <= 1'b0;
      end else if (tick_i && pend_q) begin
        dly_q <= dly_q - DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/afs_step_core.sv
module afs_step_core #(
  parameter int CNT_W  = afs_pkg::CNT_W,
  parameter int STEP_N = afs_pkg::STEP_N,
  parameter int STEP_W = afs_pkg::STEP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               long_tab_i,
  input  logic               hard_rst_i,
  input  logic               soft_rst_i,
  input  logic               apply_i,
  input  logic               apply_five_i,
  output afs_pkg::seq_mode_e mode_o,
  output logic               evt_valid_o,
  output logic [STEP_W-1:0]  evt_step_o
);
  import afs_pkg::*;

  localparam logic [CNT_W-1:0] PWR_CNT = CNT_W'(step_interval(1'b0, MODE_FOUR, '0));

  seq_mode_e         mode_q, lut_mode;
  logic [STEP_W-1:0] step_q, step_nx, lut_idx;
  logic [CNT_W-1:0]  cnt_q, cnt_dec, lut_ticks;
  logic              rst_any, hit;

  assign rst_any = hard_rst_i || soft_rst_i;
  assign step_nx = (step_q == STEP_W'(STEP_N - 1)) ? '0 : step_q + STEP_W'(1);
  assign cnt_dec = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
  assign hit     = (cnt_dec == '0);

  always_comb begin
    lut_idx  = step_nx;
    lut_mode = mode_q;
    if (rst_any) begin
      lut_idx  = '0;
      lut_mode = hard_rst_i ? MODE_FOUR : mode_q;
    end else if (apply_i) begin
      lut_idx  = '0;
      lut_mode = seq_mode_e'(apply_five_i);
    end
  end

  afs_interval_lut #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_lut (
    .long_tab_i (long_tab_i),
    .mode_i     (lut_mode),
    .idx_i      (lut_idx),
    .ticks_o    (lut_ticks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_FOUR;
      step_q      <= '0;
      cnt_q       <= PWR_CNT;
      evt_valid_o <= 1'b0;
      evt_step_o  <= '0;
    end else begin
      evt_valid_o <= 1'b0;
      if (rst_any) begin
        mode_q <= lut_mode;
        step_q <= '0;
        cnt_q  <= lut_ticks;
      end else if (apply_i) begin
        mode_q <= lut_mode;
        step_q <= '0;
        // five-step mode consumes one tick on reload
        cnt_q  <= apply_five_i ? lut_ticks - CNT_W'(1) : lut_ticks;
      end else if (tick_i) begin
        if (hit) begin
          evt_valid_o <= 1'b1;
          evt_step_o  <= step_q;
          step_q      <= step_nx;
          cnt_q       <= lut_ticks;
        end else begin
          cnt_q <= cnt_dec;
        end
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq #(
  parameter int         CNT_W      = afs_pkg::CNT_W,
  parameter int         STEP_N     = afs_pkg::STEP_N,
  parameter int         STEP_W     = $clog2(STEP_N),
  parameter int         DLY_W      = 3,
  parameter int         DLY_EVEN   = 3,
  parameter int         DLY_ODD    = 4,
  parameter logic [1:0] REGION_LONG = 2'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_odd_i,
  input  logic [1:0]        region_i,
  input  logic              hard_rst_i,
  input  logic              soft_rst_i,
  output logic              evt_valid_o,
  output logic [STEP_W-1:0] evt_step_o,
  output logic              wr_apply_o
);
  import afs_pkg::*;

  seq_mode_e mode;
  logic      apply, apply_five, rst_any, rst_five, long_tab;
  logic      unused_data;

  assign unused_data = ^wr_data_i[6:0];
  assign rst_any     = hard_rst_i || soft_rst_i;
  assign rst_five    = !hard_rst_i && (mode == MODE_FIVE);
  assign long_tab    = (region_i == REGION_LONG);

  afs_write_queue #(
    .DLY_W(DLY_W), .DLY_EVEN(DLY_EVEN), .DLY_ODD(DLY_ODD), .DLY_RST(DLY_EVEN)
  ) u_wq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .wr_i          (wr_i),
    .wr_five_i     (wr_data_i[7]),
    .wr_odd_i      (wr_odd_i),
    .rst_any_i     (rst_any),
    .rst_five_i    (rst_five),
    .apply_o       (apply),
    .apply_five_o  (apply_five),
    .apply_pulse_o (wr_apply_o)
  );

  afs_step_core #(.CNT_W(CNT_W), .STEP_N(STEP_N), .STEP_W(STEP_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .long_tab_i   (long_tab),
    .hard_rst_i   (hard_rst_i),
    .soft_rst_i   (soft_rst_i),
    .apply_i      (apply),
    .apply_five_i (apply_five),
    .mode_o       (mode),
    .evt_valid_o  (evt_valid_o),
    .evt_step_o   (evt_step_o)
  );
endmodule

// File: rtl/audio_frame_seq_chk.sv
module audio_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_i,
  input logic       hard_rst_i,
  input logic       soft_rst_i,
  input logic       evt_valid_o,
  input logic [2:0] evt_step_o,
  input logic       wr_apply_o
);
  // R5
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> evt_step_o < 3'd6);

  // R5
  step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && $past(evt_valid_o)) |->
      evt_step_o == (($past(evt_step_o) == 3'd5) ? 3'd0 : $past(evt_step_o) + 3'd1));

  // R6
  apply_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_apply_o |-> !evt_valid_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!evt_valid_o && !wr_apply_o));

  // R9
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_rst_i || soft_rst_i) |=> (!evt_valid_o && !wr_apply_o));

  // R8
  wr_supersede_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !wr_apply_o);
endmodule

bind audio_frame_seq audio_frame_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wr_i        (wr_i),
  .hard_rst_i  (hard_rst_i),
  .soft_rst_i  (soft_rst_i),
  .evt_valid_o (evt_valid_o),
  .evt_step_o  (evt_step_o),
  .wr_apply_o  (wr_apply_o)
);

// File: tb/audio_frame_seq_tb.sv
module audio_frame_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wr_odd_i = 1'b0;
  logic [1:0] region_i = 2'd0;
  logic       hard_rst_i = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       evt_valid_o, wr_apply_o;
  logic [2:0] evt_step_o;

  always #10 clk_i = ~clk_i;

  audio_frame_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .wr_odd_i(wr_odd_i), .region_i(region_i),
    .hard_rst_i(hard_rst_i), .soft_rst_i(soft_rst_i),
    .evt_valid_o(evt_valid_o), .evt_step_o(evt_step_o), .wr_apply_o(wr_apply_o)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    started = 0;
  int    n_evt = 0;

  // reference model state
  int m_five, m_step, m_cnt, m_pend, m_pfive, m_dly;
  int e_ev, e_step, e_ap;

  function automatic int tab(int long_t, int five, int idx);
    int s4[6] = '{7457, 7456, 7458, 7457, 1, 1};
    int s5[6] = '{7457, 7456, 7458, 7458, 7452, 1};
    int l4[6] = '{8313, 8314, 8312, 8313, 1, 1};
    int l5[6] = '{8313, 8314, 8312, 8314, 8312, 1};
    if (long_t != 0) return five != 0 ? l5[idx] : l4[idx];
    return five != 0 ? s5[idx] : s4[idx];
  endfunction

  task automatic m_clock(int lt);
    if (m_cnt > 0) m_cnt--;
    if (m_cnt == 0) begin
      e_ev = 1; e_step = m_step;
      m_step = (m_step + 1) % 6;
      m_cnt = tab(lt, m_five, m_step);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_five = 0; m_step = 0; m_cnt = 7457; m_pend = 0; m_pfive = 0; m_dly = 0;
      e_ev = 0; e_step = 0; e_ap = 0;
    end else begin
      int lt;
      lt = (region_i == 2'd1) ? 1 : 0;
      e_ev = 0; e_ap = 0;
      if (hard_rst_i || soft_rst_i) begin
        if (hard_rst_i) m_five = 0;
        m_step = 0; m_cnt = tab(lt, m_five, 0);
        m_pend = 1; m_pfive = m_five; m_dly = 3;
      end else begin
        if (wr_i) begin
          m_pend = 1; m_pfive = wr_data_i[7]; m_dly = wr_odd_i ? 4 : 3;
          if (tick_i) m_clock(lt);
        end else if (tick_i && m_pend != 0 && m_dly == 1) begin
          m_pend = 0; m_five = m_pfive; m_step = 0;
          m_cnt = tab(lt, m_five, 0);
          if (m_five != 0) m_cnt--;
          e_ap = 1;
        end else if (tick_i) begin
          if (m_pend != 0) m_dly--;
          m_clock(lt);
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (started) begin
      chk(cur_req, "evt_valid", int'(evt_valid_o), e_ev);
      if (e_ev != 0) begin
        chk(cur_req, "evt_step", int'(evt_step_o), e_step);
        n_evt++;
      end
      chk(cur_req, "wr_apply", int'(wr_apply_o), e_ap);
    end
  end

  int wd = 0;
  always @(posedge clk_i) begin
    wd++;
    if (wd > 190000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 190000);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write(logic [7:0] d, logic odd);
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = d; wr_odd_i = odd;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic pulse_rst(bit hard);
    @(negedge clk_i);
    if (hard) hard_rst_i = 1'b1; else soft_rst_i = 1'b1;
    @(negedge clk_i);
    hard_rst_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "rst evt_valid", int'(evt_valid_o), 0);
    chk("R1", "rst wr_apply", int'(wr_apply_o), 0);
    rst_ni = 1'b1;
    started = 1;
    cur_req = "R1"; run(7500);
    chk("R1", "events seen", n_evt, 1);

    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      tick_i = (i % 3) != 0;
      if (i == 1000) begin wr_i = 1'b1; wr_data_i = 8'h00; wr_odd_i = 1'b1; end
      else wr_i = 1'b0;
    end
    tick_i = 1'b1;

    cur_req = "R3"; run(30000);
    cur_req = "R2"; write(8'h80, 1'b0);
    cur_req = "R7"; run(38000);

    cur_req = "R8";
    write(8'h00, 1'b1); run(2);
    write(8'h7f, 1'b0); run(1);
    write(8'h80, 1'b0); run(30);
    write(8'h80, 1'b0); run(1);
    write(8'h00, 1'b0); run(40);

    cur_req = "R10";
    write(8'h80, 1'b0); run(10);
    pulse_rst(1'b0); run(8000);

    cur_req = "R11"; run(3000);
    region_i = 2'd1;
    cur_req = "R4"; run(42000);

    cur_req = "R9"; pulse_rst(1'b1); run(9000);

    cur_req = "R3"; region_i = 2'd2;
    write(8'h80, 1'b1); run(8000);
    region_i = 2'd3; run(8000);
    cur_req = "R6"; write(8'h00, 1'b1); run(20);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule